// File: doc/BRIEF.md
# Masked Condition Evaluation Unit

This block decides, at the end of every command a DMA channel executes, whether the channel should stall, take a branch, or raise an interrupt. Each of the three decisions has its own select register. A select register holds a 4-bit mask and a 4-bit compare value. The decision compares the channel's four device-status bits with the compare value, looking only at the bits the mask enables. A 2-bit mode field for each decision, carried in the current command word, then says how the comparison result is used.

The channel sequencer presents the command's mode bits and the current device status, and pulses `done_pulse` for one cycle when a command completes. One cycle later the unit answers with registered, single-cycle `stall_take` and `branch_take` pulses and an `irq_fire` pulse. The interrupt pulse also sets `irq_pending`, a level that stays high until the channel's interrupt is acknowledged. The select registers are loaded through a plain 32-bit write port. Nothing streams through this block, so every pin is plain control or status with no handshake.

Top module: `cond_eval_unit`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first decision, `stall_take`, `branch_take`, `irq_fire` and `irq_pending` are 0. All three select registers reset to mask 0 and value 0.
- R2: When `wr_en` is 1 at a rising edge, `wr_sel` picks the register to load: 0 selects stall, 1 selects branch, 2 selects interrupt. The mask is taken from `wr_data` bits 19:16 and the compare value from bits 3:0. All other data bits have no effect on any decision.
- R3: A write with `wr_sel` = 3 changes no select register.
- R4: The condition is true when (status AND mask) equals (value AND mask) over the 4 status bits. With a mask of 0 the condition is always true.
- R5: Mode fields sit in `cmd_modes`: interrupt in bits 5:4, branch in bits 3:2, stall in bits 1:0. The encoding is 0 = never, 1 = act if the condition is true, 2 = act if the condition is false, 3 = always.
- R6: In the never and always modes the outcome does not depend on status, mask or value.
- R7: A decision is output on the rising edge after the edge that samples `done_pulse` = 1, and lasts exactly one cycle. Without such a pulse all three decision outputs are 0.
- R8: Each decision uses only its own select register, while all three share the same `dev_status`.
- R9: `irq_pending` is set when `irq_fire` is issued and stays set until an edge that samples `irq_ack` = 1. If a new interrupt fires at that same edge, the new interrupt wins and `irq_pending` stays 1.
- R10: When a write and `done_pulse` occur at the same edge, the decision uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Select register write strobe |
| wr_sel | input | 2 | Write target: 0 stall, 1 branch, 2 interrupt, 3 none |
| wr_data | input | 32 | Write data: mask in 19:16, compare value in 3:0 |
| cmd_modes | input | 6 | Mode fields of the current command |
| dev_status | input | 4 | Device-status bits of the channel |
| done_pulse | input | 1 | Command-complete strobe |
| irq_ack | input | 1 | Clears the pending interrupt |
| stall_take | output | 1 | One-cycle stall decision |
| branch_take | output | 1 | One-cycle branch decision |
| irq_fire | output | 1 | One-cycle interrupt decision |
| irq_pending | output | 1 | Interrupt level held until acknowledged |

## Verification
Every decision output is due exactly one rising edge after the edge that samples `done_pulse`. `irq_pending` follows at that same edge, and it drops at the edge that samples `irq_ack`. The bench drives its inputs on the falling edge. At that moment it also computes, from its own model of the select registers, what the outputs must show after the next rising edge. It compares those predictions at the following falling edge, one cycle after the stimulus, so every result is checked in exactly the cycle it is due.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  typedef enum logic [1:0] {
    MODE_NEVER    = 2'd0,
    MODE_IF_MATCH = 2'd1,
    MODE_IF_MISS  = 2'd2,
    MODE_ALWAYS   = 2'd3
  } cmode_e;

  // decision slots; slot index also selects the mode field and write target
  localparam int DEC_STALL  = 0;
  localparam int DEC_BRANCH = 1;
  localparam int DEC_IRQ    = 2;
  localparam int N_DEC      = 3;
  localparam int MODE_W     = 2;
endpackage

// File: rtl/cond_sel_regs.sv
module cond_sel_regs #(
  parameter int N_SEL    = 3,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0,
  localparam int SEL_W   = $clog2(N_SEL + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [N_SEL-1:0][STAT_W-1:0]   sel_mask,
  output logic [N_SEL-1:0][STAT_W-1:0]   sel_val
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data;

  for (genvar g = 0; g < N_SEL; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_mask[g] <= '0;
        sel_val[g]  <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        sel_mask[g] <= wr_data[MASK_LSB +: STAT_W];
        sel_val[g]  <= wr_data[VAL_LSB +: STAT_W];
      end
    end
  end
endmodule

// File: rtl/cond_match.sv
module cond_match
  import cond_eval_pkg::*;
#(
  parameter int STAT_W = 4
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [STAT_W-1:0] mask,
  input  logic [STAT_W-1:0] cmp_val,
  input  logic [STAT_W-1:0] status,
  output logic              act
);
  logic hit;
  assign hit = ((status & mask) == (cmp_val & mask));

  always_comb begin
    case (mode)
      MODE_NEVER:    act = 1'b0;
      MODE_IF_MATCH: act = hit;
      MODE_IF_MISS:  act = !hit;
      default:       act = 1'b1;
    endcase
  end
endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
  import cond_eval_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 4,
  parameter int MASK_LSB = 16,
  parameter int VAL_LSB  = 0,
  localparam int SEL_W   = $clog2(N_DEC + 1),
  localparam int MODES_W = N_DEC * MODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [MODES_W-1:0] cmd_modes,
  input  logic [STAT_W-1:0]  dev_status,
  input  logic               done_pulse,
  input  logic               irq_ack,
  output logic               stall_take,
  output logic               branch_take,
  output logic               irq_fire,
  output logic               irq_pending
);
  logic [N_DEC-1:0][STAT_W-1:0] sel_mask;
  logic [N_DEC-1:0][STAT_W-1:0] sel_val;
  logic [N_DEC-1:0]             act;
  logic [N_DEC-1:0]             dec_q;

  cond_sel_regs #(
    .N_SEL(N_DEC), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .MASK_LSB(MASK_LSB), .VAL_LSB(VAL_LSB)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sel_mask(sel_mask), .sel_val(sel_val)
  );

  for (genvar g = 0; g < N_DEC; g++) begin : g_dec
    cond_match #(.STAT_W(STAT_W)) u_match (
      .mode(cmd_modes[g*MODE_W +: MODE_W]),
      .mask(sel_mask[g]),
      .cmp_val(sel_val[g]),
      .status(dev_status),
      .act(act[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q       <= '0;
      irq_pending <= 1'b0;
    end else begin
      dec_q       <= done_pulse ? act : '0;
      irq_pending <= (done_pulse && act[DEC_IRQ]) || (irq_pending && !irq_ack);
    end
  end

  assign stall_take  = dec_q[DEC_STALL];
  assign branch_take = dec_q[DEC_BRANCH];
  assign irq_fire    = dec_q[DEC_IRQ];
endmodule

// File: rtl/cond_eval_unit_chk.sv
module cond_eval_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] cmd_modes,
  input logic       done_pulse,
  input logic       irq_ack,
  input logic       stall_take,
  input logic       branch_take,
  input logic       irq_fire,
  input logic       irq_pending
);
  // R7: no decision without a completion strobe
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pulse |=> !(stall_take || branch_take || irq_fire));

  // R6: never mode yields nothing, always mode yields the action
  assert_stall_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cmd_modes[1:0] == 2'd0) |=> !stall_take);
  assert_stall_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cmd_modes[1:0] == 2'd3) |=> stall_take);
  assert_branch_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cmd_modes[3:2] == 2'd3) |=> branch_take);
  assert_irq_never_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && cmd_modes[5:4] == 2'd0) |=> !irq_fire);

  // R9: pending level behaviour
  assert_fire_sets_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |-> irq_pending);
  assert_pending_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_ack) |=> irq_pending);
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (irq_pending == irq_fire));
endmodule

bind cond_eval_unit cond_eval_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_modes(cmd_modes), .done_pulse(done_pulse),
  .irq_ack(irq_ack), .stall_take(stall_take), .branch_take(branch_take),
  .irq_fire(irq_fire), .irq_pending(irq_pending)
);

// File: tb/cond_eval_unit_tb_top.sv
`timescale 1ns/1ps
module cond_eval_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  cmd_modes = '0;
  logic [3:0]  dev_status = '0;
  logic        done_pulse = 1'b0;
  logic        irq_ack = 1'b0;
  logic        stall_take, branch_take, irq_fire, irq_pending;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state: index 0 stall, 1 branch, 2 interrupt
  int m_mask[3];
  int m_val[3];
  bit e_stall = 0, e_branch = 0, e_fire = 0, e_pend = 0;

  always #2.5 clk = ~clk;

  cond_eval_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_modes(cmd_modes), .dev_status(dev_status), .done_pulse(done_pulse),
    .irq_ack(irq_ack), .stall_take(stall_take), .branch_take(branch_take),
    .irq_fire(irq_fire), .irq_pending(irq_pending)
  );

  function automatic bit decide(int mode, int idx, int st);
    bit c;
    c = ((st & m_mask[idx]) == (m_val[idx] & m_mask[idx]));
    if (mode == 0) return 0;
    if (mode == 3) return 1;
    if (mode == 1) return c;
    return !c;
  endfunction

  task automatic cmp1(string req, string nm, bit act, bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp1("R4 R5 R7", "stall_take", stall_take, e_stall);
    cmp1("R4 R5 R7", "branch_take", branch_take, e_branch);
    cmp1("R4 R5 R7", "irq_fire", irq_fire, e_fire);
    cmp1("R9", "irq_pending", irq_pending, e_pend);
  endtask

  // one cycle: check previous prediction, apply inputs, predict next
  task automatic step(bit we, int sel, logic [31:0] data, int modes, int st, bit dn, bit ack);
    @(negedge clk);
    compare_all();
    wr_en = we; wr_sel = 2'(sel); wr_data = data;
    cmd_modes = 6'(modes); dev_status = 4'(st); done_pulse = dn; irq_ack = ack;
    e_stall  = dn && decide(modes & 3, 0, st);
    e_branch = dn && decide((modes >> 2) & 3, 1, st);
    e_fire   = dn && decide((modes >> 4) & 3, 2, st);
    e_pend   = e_fire || (e_pend && !ack);
    if (we && sel < 3) begin   // R10: model updates after prediction
      m_mask[sel] = int'(data[19:16]);
      m_val[sel]  = int'(data[3:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_mask[i] = 0; m_val[i] = 0; end
    // R1: outputs low during reset
    repeat (3) @(negedge clk);
    cmp1("R1", "stall_take", stall_take, 0);
    cmp1("R1", "branch_take", branch_take, 0);
    cmp1("R1", "irq_fire", irq_fire, 0);
    cmp1("R1", "irq_pending", irq_pending, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    // R1 R4: reset registers have mask 0, so if-match holds and if-miss does not
    step(0, 0, 0, 6'b01_01_01, 4'hA, 1, 0);
    step(0, 0, 0, 6'b10_10_10, 4'h5, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    // R6: never and always ignore status
    step(0, 0, 0, 6'b11_00_11, 4'hF, 1, 0);
    step(0, 0, 0, 6'b00_11_00, 4'h0, 1, 1);
    // R2: branch select mask 3 value 1 with junk in other bits
    step(1, 1, 32'hA5F3_5AF1, 0, 0, 0, 0);
    step(0, 0, 0, 6'b00_01_00, 4'b1101, 1, 0);
    step(0, 0, 0, 6'b00_01_00, 4'b1110, 1, 0);
    step(0, 0, 0, 6'b00_10_00, 4'b1110, 1, 0);
    // R8: stall keeps its own (zero-mask) register while branch misses
    step(0, 0, 0, 6'b00_01_01, 4'b0000, 1, 0);
    // R3: write to slot 3 must change nothing
    step(1, 3, 32'h000F_000F, 0, 0, 0, 0);
    step(0, 0, 0, 6'b01_01_01, 4'b0000, 1, 0);
    // R2: interrupt select mask 8 value 8
    step(1, 2, 32'h0008_0008, 0, 0, 0, 0);
    step(0, 0, 0, 6'b01_00_00, 4'b0111, 1, 0);
    step(0, 0, 0, 6'b01_00_00, 4'b1000, 1, 0);
    // R9: pending holds, then ack with simultaneous fire keeps it set
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 6'b11_00_00, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    // R10: write stall select during done; old value (mask 0) is used
    step(1, 0, 32'h000F_0005, 6'b00_00_10, 4'h0, 1, 0);
    step(0, 0, 0, 6'b00_00_10, 4'h0, 1, 0);
    step(0, 0, 0, 6'b00_00_01, 4'h5, 1, 0);
    // mixed random traffic covering R2 R4 R5 R7 R8 R9
    for (int n = 0; n < 600; n++) begin
      step($urandom_range(0, 3) == 0, int'($urandom_range(0, 3)), $urandom,
           int'($urandom_range(0, 63)), int'($urandom_range(0, 15)),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule